// File: doc/BRIEF.md
# Machine Counter Register Bank

This block holds the two 64-bit free-running counters a processor core exposes through its control and status register space. One counter counts clock cycles. The other counts retired instructions, and it advances on a one-cycle retire pulse from the pipeline. A 64-bit wall-clock value arrives on an input port and is only passed through for reading.

The core's register-access stage drives a 12-bit address, a write strobe and write data. Read data comes back combinationally in the same cycle. A hit flag tells the core whether the address belongs to this bank.

The parameter `XLEN` selects 32 or 64 bits. When `XLEN` is 32, each counter is reached as two separately addressed halves. Unprivileged read-only aliases return the two counters and the time value.

Top module: `mcnt_csr_bank`

## Requirements
- R1: While `rst_n` is low, both counters are held at zero, and they read as zero at 0xB00 and 0xB02.
- R2: The cycle counter increases by one on every clock edge on which it is not written, and it wraps from all-ones to zero modulo 2^64.
- R3: The retired counter increases by one on each edge where `retire_i` is 1 and the counter is not written. Otherwise it holds its value.
- R4: A write to a counter takes priority over its increment. A write to the retired counter, to either half, cancels the increment from a `retire_i` pulse in the same cycle.
- R5: With `XLEN`=32, address 0xB00 (cycle) and address 0xB02 (retired) hold bits 31:0, while 0xB80 (cycle) and 0xB82 (retired) hold bits 63:32. A write to one half leaves the other half unchanged. With `XLEN`=64, 0xB00 and 0xB02 hold all 64 bits.
- R6: The read-only aliases are 0xC00 (cycle), 0xC01 (time) and 0xC02 (retired), each giving bits XLEN-1:0. With `XLEN`=32, the aliases 0xC80, 0xC81 and 0xC82 give bits 63:32.
- R7: Writes to any alias address change no counter.
- R8: Reads of the time aliases return the matching bits of `time_i` in the same cycle.
- R9: With `XLEN`=64, the addresses 0xB80, 0xB82, 0xC80, 0xC81 and 0xC82 do not exist: `csr_hit_o` is 0, the read data is 0, and writes to them are ignored.
- R10: Any address outside the bank gives `csr_hit_o`=0 and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One pulse per retired instruction |
| time_i | input | 64 | External wall-clock value |
| csr_we_i | input | 1 | Write strobe |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data, combinational |
| csr_hit_o | output | 1 | Address belongs to this bank |

## Verification
A 32-bit instance is stepped through a vector table of writes and reads.

- Writing the low half of the cycle counter to all-ones and then loading its high half shows that the low half survives a write to the high half. The next free-running edge then shows the carry into the upper half.
- Writes to the retired counter with `retire_i` high tell a correct cancel apart from a write followed by an extra increment.
- Writes aimed at the alias addresses show that those addresses are read-only.
- Reading `time_i` through both halves checks the pass-through of the time value.

A 64-bit instance checks wrap-around at the top of the count and full-width writes. It also checks that the upper-half addresses are absent in that mode.

// File: rtl/mcnt_csr_bank.sv
module mcnt_csr_bank #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  logic [63:0]     time_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_hit_o
);
  localparam bit SPLIT = (XLEN == 32);

  logic [63:0] cyc_q, ins_q;
  logic [63:0] wd;
  logic        cyc_lo_w, cyc_hi_w, ins_lo_w, ins_hi_w;

  assign wd       = 64'(csr_wdata_i);
  assign cyc_lo_w = csr_we_i && csr_addr_i == 12'hB00;
  assign ins_lo_w = csr_we_i && csr_addr_i == 12'hB02;
  assign cyc_hi_w = SPLIT && csr_we_i && csr_addr_i == 12'hB80;
  assign ins_hi_w = SPLIT && csr_we_i && csr_addr_i == 12'hB82;

  always_ff @(posedge clk) begin
    if (!rst_n)        cyc_q <= '0;
    else if (cyc_lo_w) cyc_q <= SPLIT ? {cyc_q[63:32], wd[31:0]} : wd;
    else if (cyc_hi_w) cyc_q <= {wd[31:0], cyc_q[31:0]};
    else               cyc_q <= cyc_q + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ins_q <= '0;
    else if (ins_lo_w) ins_q <= SPLIT ? {ins_q[63:32], wd[31:0]} : wd;
    else if (ins_hi_w) ins_q <= {wd[31:0], ins_q[31:0]};
    else if (retire_i) ins_q <= ins_q + 64'd1;
  end

  always_comb begin
    csr_hit_o   = 1'b1;
    csr_rdata_o = '0;
    unique case (csr_addr_i)
      12'hB00, 12'hC00: csr_rdata_o = XLEN'(cyc_q);
      12'hB02, 12'hC02: csr_rdata_o = XLEN'(ins_q);
      12'hC01:          csr_rdata_o = XLEN'(time_i);
      12'hB80, 12'hC80: if (SPLIT) csr_rdata_o = XLEN'(cyc_q[63:32]); else csr_hit_o = 1'b0;
      12'hB82, 12'hC82: if (SPLIT) csr_rdata_o = XLEN'(ins_q[63:32]); else csr_hit_o = 1'b0;
      12'hC81:          if (SPLIT) csr_rdata_o = XLEN'(time_i[63:32]); else csr_hit_o = 1'b0;
      default:          csr_hit_o = 1'b0;
    endcase
  end
endmodule

module mcnt_csr_bank_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            retire_i,
  input logic            csr_we_i,
  input logic [11:0]     csr_addr_i,
  input logic [XLEN-1:0] csr_wdata_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            csr_hit_o,
  input logic [63:0]     cyc_q,
  input logic [63:0]     ins_q
);
  logic cyc_touch, ins_touch;
  assign cyc_touch = csr_we_i && (csr_addr_i == 12'hB00 || (XLEN == 32 && csr_addr_i == 12'hB80));
  assign ins_touch = csr_we_i && (csr_addr_i == 12'hB02 || (XLEN == 32 && csr_addr_i == 12'hB82));

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (cyc_q == 64'd0 && ins_q == 64'd0));
  // R2
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_touch |=> cyc_q == $past(cyc_q) + 64'd1);
  // R3
  retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_touch && retire_i) |=> ins_q == $past(ins_q) + 64'd1);
  // R3
  retire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_touch && !retire_i) |=> $stable(ins_q));
  // R4
  retire_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_addr_i == 12'hB02) |=> ins_q[XLEN-1:0] == $past(csr_wdata_i));
  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_hit_o |-> csr_rdata_o == '0);
endmodule

bind mcnt_csr_bank mcnt_csr_bank_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .csr_we_i(csr_we_i),
  .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
  .csr_hit_o(csr_hit_o), .cyc_q(cyc_q), .ins_q(ins_q)
);

// File: tb/mcnt_csr_bank_tb_top.sv
`timescale 1ns/1ps
module mcnt_csr_bank_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  localparam logic [63:0] TIME_V = 64'hAAAA_BBBB_CCCC_DDDD;

  logic        ret32 = 0, we32 = 0;
  logic [11:0] addr32 = 12'hB00;
  logic [31:0] wd32 = '0, rd32;
  logic        hit32;

  logic        ret64 = 0, we64 = 0;
  logic [11:0] addr64 = 12'hB00;
  logic [63:0] wd64 = '0, rd64;
  logic        hit64;

  mcnt_csr_bank #(.XLEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .retire_i(ret32), .time_i(TIME_V),
    .csr_we_i(we32), .csr_addr_i(addr32), .csr_wdata_i(wd32),
    .csr_rdata_o(rd32), .csr_hit_o(hit32));

  mcnt_csr_bank #(.XLEN(64)) dut64_i (
    .clk(clk), .rst_n(rst_n), .retire_i(ret64), .time_i(TIME_V),
    .csr_we_i(we64), .csr_addr_i(addr64), .csr_wdata_i(wd64),
    .csr_rdata_o(rd64), .csr_hit_o(hit64));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // {we, waddr, wdata, retire, raddr, expected}
  localparam int NV = 14;
  localparam logic [89:0] VEC [NV] = '{
    {1'b1, 12'hB00, 32'hFFFF_FFFF, 1'b0, 12'hB00, 32'hFFFF_FFFF}, // R5
    {1'b1, 12'hB80, 32'h1234_5678, 1'b0, 12'hB00, 32'hFFFF_FFFF}, // R5 low kept
    {1'b0, 12'hB00, 32'h0,         1'b0, 12'hB80, 32'h1234_5679}, // R2 carry
    {1'b0, 12'hB00, 32'h0,         1'b0, 12'hB00, 32'h0000_0001}, // R2
    {1'b1, 12'hB02, 32'h0000_000A, 1'b1, 12'hB02, 32'h0000_000A}, // R4
    {1'b0, 12'hB00, 32'h0,         1'b1, 12'hB02, 32'h0000_000B}, // R3
    {1'b0, 12'hB00, 32'h0,         1'b0, 12'hC02, 32'h0000_000B}, // R3 R6
    {1'b1, 12'hB82, 32'h0000_0005, 1'b1, 12'hB02, 32'h0000_000B}, // R4 R5
    {1'b0, 12'hB00, 32'h0,         1'b0, 12'hC82, 32'h0000_0005}, // R6
    {1'b1, 12'hC00, 32'h0,         1'b0, 12'hC00, 32'h0000_0007}, // R7
    {1'b1, 12'hC02, 32'h0,         1'b1, 12'hB02, 32'h0000_000C}, // R7
    {1'b0, 12'hB00, 32'h0,         1'b0, 12'hC81, 32'hAAAA_BBBB}, // R8
    {1'b0, 12'hB00, 32'h0,         1'b0, 12'hC01, 32'hCCCC_DDDD}, // R8
    {1'b0, 12'hB00, 32'h0,         1'b0, 12'h7C0, 32'h0000_0000}  // R10
  };

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    addr32 = 12'hB00; addr64 = 12'hB02; #1;
    check("R1 cycle in reset", {32'h0, rd32}, 64'h0);
    check("R1 retired in reset", rd64, 64'h0);
    addr32 = 12'hB02; #1;
    check("R1 retired32 in reset", {32'h0, rd32}, 64'h0);

    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      we32 = VEC[i][89]; addr32 = VEC[i][88:77]; wd32 = VEC[i][76:45]; ret32 = VEC[i][44];
      @(posedge clk); #1;
      we32 = 0; ret32 = 0; addr32 = VEC[i][43:32]; #1;
      check($sformatf("vector %0d R2-R10 table", i), {32'h0, rd32}, {32'h0, VEC[i][31:0]});
      @(negedge clk);
    end
    addr32 = 12'h7C0; #1;
    check("R10 hit on unmapped", {63'h0, hit32}, 64'h0);

    // 64-bit instance
    we64 = 1; addr64 = 12'hB00; wd64 = 64'hFFFF_FFFF_FFFF_FFFF;
    @(posedge clk); #1; we64 = 0; #1;
    check("R5 full-width write", rd64, 64'hFFFF_FFFF_FFFF_FFFF);
    @(posedge clk); #2;
    check("R2 wrap to zero", rd64, 64'h0);
    @(negedge clk);
    we64 = 1; addr64 = 12'hB02; wd64 = 64'h1_0000_0002; ret64 = 1;
    @(posedge clk); #1; we64 = 0; ret64 = 0; #1;
    check("R4 full-width retired write", rd64, 64'h1_0000_0002);
    @(negedge clk);
    we64 = 1; addr64 = 12'hB82; wd64 = 64'h55;
    @(posedge clk); #1; we64 = 0; addr64 = 12'hB02; #1;
    check("R9 write to absent high half ignored", rd64, 64'h1_0000_0002);
    addr64 = 12'hB80; #1;
    check("R9 absent read zero", rd64, 64'h0);
    check("R9 absent hit low", {63'h0, hit64}, 64'h0);
    addr64 = 12'hC01; #1;
    check("R8 time full width", rd64, TIME_V);
    check("R6 alias hit", {63'h0, hit64}, 64'h1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule